// File: doc/BRIEF.md
# Phase Activation Token Controller

This block decides when one phase of a multiphase converter controller starts a charge cycle. There are two reasons to activate. A circulating token arrives from the previous phase. Separately, a cleaned-up high-load flag says every phase must charge at once. Each reason has its own small requester. Both feed one arbiter. The arbiter owns the single four-phase request/acknowledge channel to the charging logic and sends the acknowledge back only to the requester it is serving.

The token requester keeps the token for a minimum time. A down-counter is loaded from `hold_cycles` when the token arrives. The token is passed on as a one-cycle `tok_out` pulse only when two things are true: the charging handshake has fully returned to idle, and the counter has reached zero. When the high-load requester is acknowledged, it pulses `hl_clr` so the external flag latch can be cleared. The asynchronous active-low reset is released through a short synchronizer. If the `INIT_TOKEN` parameter is set, the phase leaves reset holding the token.

Top module: `phase_act_ctrl`

## Requirements
- R1: After reset with `INIT_TOKEN`=0, `chg_req`, `tok_out` and `hl_clr` stay low until a stimulus arrives.
- R2: A `tok_in` pulse sampled at clock edge E raises `chg_req` after edge E+1 (two edges after the token was driven).
- R3: The token is passed only after the charging acknowledge has fallen and the hold counter has expired. When the handshake finishes first, `tok_out` rises after edge E+`hold_cycles`+1. When the acknowledge is slow, `tok_out` comes after the cycle in which `chg_ack` fell.
- R4: `tok_out` is high for exactly one cycle per pass.
- R5: A high `hl_flag` raises a charging request whether or not the phase holds the token. On the acknowledge, `hl_clr` pulses once.
- R6: The acknowledge goes only to the source being served. A token handshake never pulses `hl_clr`, and a high-load handshake never produces `tok_out`.
- R7: When both sources request in the same cycle, the high-load request is served first. The token request stays pending and is served in the next handshake, so there are two separate `chg_req` rises.
- R8: The channel is four-phase. `chg_req` stays high until `chg_ack` is high, and `chg_req` never rises while `chg_ack` is still high.
- R9: A `tok_in` pulse that arrives while the phase already holds a token is ignored. It causes no second request and no second pass.
- R10: With `INIT_TOKEN`=1, the phase leaves reset holding the token. It issues one charging request and passes the token once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold_cycles | input | HOLD_W | Minimum token hold, in cycles, loaded at token arrival |
| tok_in | input | 1 | One-cycle pulse: token handed over by the previous phase |
| hl_flag | input | 1 | Sanitized, latched high-load condition |
| chg_ack | input | 1 | Acknowledge from the charging logic |
| tok_out | output | 1 | One-cycle pulse: token handed to the next phase |
| chg_req | output | 1 | Activation request to the charging logic |
| hl_clr | output | 1 | One-cycle pulse clearing the external high-load latch |

## Verification
The main instance uses the defaults (`HOLD_W`=8, `INIT_TOKEN`=0). Its `hold_cycles` values range from 2 to 20. Short holds make the acknowledge latency the deciding factor, and long holds make the counter the deciding factor, so both orderings in R3 are reached. The responder's acknowledge latency is varied from 0 to 15 cycles.

A second instance is built with `INIT_TOKEN`=1 and `hold_cycles`=4, so the boot path that loads the counter without any `tok_in` is also exercised.

// File: rtl/phase_act_pkg.sv
package phase_act_pkg;

  typedef enum logic [2:0] {
    TK_IDLE,
    TK_BOOT,
    TK_REQ,
    TK_DROP,
    TK_HOLD
  } tk_state_e;

  typedef enum logic [1:0] {
    HS_IDLE,
    HS_REQ,
    HS_DROP
  } hs_state_e;

  typedef enum logic [1:0] {
    MG_IDLE,
    MG_BUSY,
    MG_RET
  } mg_state_e;

  typedef enum logic {
    OWN_HL,
    OWN_TK
  } owner_e;

endpackage

// File: rtl/hold_timer.sv
module hold_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);

  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load | (cnt_q != '0);
    cnt_d  = load ? load_val : (cnt_q - ONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);

  p_load_value_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(load_val)));

  p_count_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !done) |=> (cnt_q == $past(cnt_q) - ONE));

endmodule

// File: rtl/tok_ctrl.sv
module tok_ctrl
  import phase_act_pkg::*;
#(
  parameter bit INIT_TOKEN = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tok_in,
  input  logic ack,
  input  logic done,
  output logic req,
  output logic tmr_load,
  output logic tok_out
);

  localparam tk_state_e RST_ST = INIT_TOKEN ? TK_BOOT : TK_IDLE;

  tk_state_e st_q, st_d;
  logic      pass_q, pass_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      TK_IDLE: if (tok_in) st_d = TK_REQ;
      TK_BOOT: st_d = TK_REQ;
      TK_REQ:  if (ack)    st_d = TK_DROP;
      TK_DROP: if (!ack)   st_d = TK_HOLD;
      TK_HOLD: if (done)   st_d = TK_IDLE;
      default: st_d = TK_IDLE;
    endcase
    pass_d = (st_q == TK_HOLD) && done;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RST_ST;
      pass_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      pass_q <= pass_d;
    end
  end

  assign req      = (st_q == TK_REQ);
  assign tmr_load = ((st_q == TK_IDLE) && tok_in) || (st_q == TK_BOOT);
  assign tok_out  = pass_q;

  p_pass_after_timer_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tok_out |-> $past(done));

  p_single_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tok_out |=> !tok_out);

  p_dup_token_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == TK_HOLD || st_q == TK_DROP) && tok_in) |=> (st_q != TK_REQ));

endmodule

// File: rtl/hl_handler.sv
module hl_handler
  import phase_act_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hl_flag,
  input  logic ack,
  output logic req,
  output logic hl_clr
);

  hs_state_e st_q, st_d;
  logic      clr_q, clr_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      HS_IDLE: if (hl_flag) st_d = HS_REQ;
      HS_REQ:  if (ack)     st_d = HS_DROP;
      HS_DROP: if (!ack)    st_d = HS_IDLE;
      default: st_d = HS_IDLE;
    endcase
    clr_d = (st_q == HS_REQ) && ack;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= HS_IDLE;
      clr_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      clr_q <= clr_d;
    end
  end

  assign req    = (st_q == HS_REQ);
  assign hl_clr = clr_q;

  p_clr_after_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hl_clr |-> $past(ack));

  p_req_waits_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !ack) |=> req);

endmodule

// File: rtl/act_merge.sv
module act_merge
  import phase_act_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_hl,
  input  logic req_tk,
  input  logic chg_ack,
  output logic chg_req,
  output logic ack_hl,
  output logic ack_tk
);

  mg_state_e st_q, st_d;
  owner_e    own_q, own_d;
  logic      own_en;
  logic      own_req;

  always_comb begin
    own_req = (own_q == OWN_HL) ? req_hl : req_tk;
    st_d    = st_q;
    own_d   = req_hl ? OWN_HL : OWN_TK;
    own_en  = (st_q == MG_IDLE) && (req_hl || req_tk);
    unique case (st_q)
      MG_IDLE: if (req_hl || req_tk) st_d = MG_BUSY;
      MG_BUSY: if (!own_req)         st_d = MG_RET;
      MG_RET:  if (!chg_ack)         st_d = MG_IDLE;
      default: st_d = MG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= MG_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      own_q <= OWN_HL;
    else if (own_en) own_q <= own_d;
  end

  assign chg_req = (st_q == MG_BUSY);
  assign ack_hl  = chg_ack && (st_q != MG_IDLE) && (own_q == OWN_HL);
  assign ack_tk  = chg_ack && (st_q != MG_IDLE) && (own_q == OWN_TK);

  p_ack_one_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ack_hl, ack_tk}));

  p_hold_until_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_req && !chg_ack) |=> chg_req);

  p_no_rise_under_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!chg_req && chg_ack) |=> !chg_req);

  p_hl_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == MG_IDLE) && req_hl && req_tk) |=> (chg_req && !ack_tk));

endmodule

// File: rtl/phase_act_ctrl.sv
module phase_act_ctrl #(
  parameter int HOLD_W     = 8,
  parameter bit INIT_TOKEN = 1'b0,
  parameter int RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HOLD_W-1:0] hold_cycles,
  input  logic              tok_in,
  input  logic              hl_flag,
  input  logic              chg_ack,
  output logic              tok_out,
  output logic              chg_req,
  output logic              hl_clr
);

  logic [RST_STAGES-1:0] rst_pipe;
  logic                  rst_n_int;

  generate
    if (RST_STAGES > 1) begin : g_sync_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_pipe <= '0;
        else        rst_pipe <= {rst_pipe[RST_STAGES-2:0], 1'b1};
      end
    end else begin : g_sync_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_pipe <= '0;
        else        rst_pipe <= '1;
      end
    end
  endgenerate

  assign rst_n_int = rst_pipe[RST_STAGES-1];

  logic req_tk, req_hl, ack_tk, ack_hl;
  logic tmr_load, tmr_done;

  hold_timer #(.W(HOLD_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .load     (tmr_load),
    .load_val (hold_cycles),
    .done     (tmr_done)
  );

  tok_ctrl #(.INIT_TOKEN(INIT_TOKEN)) u_tok (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .tok_in   (tok_in),
    .ack      (ack_tk),
    .done     (tmr_done),
    .req      (req_tk),
    .tmr_load (tmr_load),
    .tok_out  (tok_out)
  );

  hl_handler u_hl (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .hl_flag (hl_flag),
    .ack     (ack_hl),
    .req     (req_hl),
    .hl_clr  (hl_clr)
  );

  act_merge u_merge (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .req_hl  (req_hl),
    .req_tk  (req_tk),
    .chg_ack (chg_ack),
    .chg_req (chg_req),
    .ack_hl  (ack_hl),
    .ack_tk  (ack_tk)
  );

  p_token_needs_request_r6: assert property (@(posedge clk) disable iff (!rst_n_int)
    $rose(ack_tk) |-> !hl_clr);

endmodule

// File: tb/phase_act_ctrl_test.sv
`timescale 1ns/1ps
module phase_act_ctrl_test;

  logic       clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n;
  logic [7:0] hold;
  logic       tok_in, hl_flag, chg_ack;
  logic       tok_out, chg_req, hl_clr;

  logic       b_ack;
  logic       b_tok_out, b_req, b_clr;

  phase_act_ctrl uut (
    .clk(clk), .rst_n(rst_n), .hold_cycles(hold), .tok_in(tok_in),
    .hl_flag(hl_flag), .chg_ack(chg_ack), .tok_out(tok_out),
    .chg_req(chg_req), .hl_clr(hl_clr)
  );

  phase_act_ctrl #(.INIT_TOKEN(1'b1)) uut_boot (
    .clk(clk), .rst_n(rst_n), .hold_cycles(8'd4), .tok_in(1'b0),
    .hl_flag(1'b0), .chg_ack(b_ack), .tok_out(b_tok_out),
    .chg_req(b_req), .hl_clr(b_clr)
  );

  int cyc = 0;
  always @(posedge clk) cyc = cyc + 1;

  int tok_req_cnt = 0, hl_req_cnt = 0, ack_lat = 0;
  int tok_seen = 0, hl_seen = 0, lat_cnt = 0;
  int n_tok = 0, n_clr = 0, n_rise = 0;
  int last_tok = 0, last_clr = 0, last_rise = 0, last_fall = 0, drv_cyc = 0;
  int viol_r8 = 0, viol_r4 = 0;
  int b_tok = 0, b_rise = 0;
  logic prev_req = 1'b0, prev_tok = 1'b0, b_prev_req = 1'b0;

  always @(negedge clk) begin
    if (!rst_n) begin
      tok_in = 1'b0; hl_flag = 1'b0; chg_ack = 1'b0; b_ack = 1'b0;
      prev_req = 1'b0; prev_tok = 1'b0; b_prev_req = 1'b0; lat_cnt = 0;
    end else begin
      if (chg_req && !prev_req) begin
        n_rise++; last_rise = cyc;
        if (chg_ack) viol_r8++;
      end
      if (!chg_req && prev_req && !chg_ack) viol_r8++;
      if (tok_out) begin
        n_tok++; last_tok = cyc;
        if (prev_tok) viol_r4++;
      end
      if (hl_clr) begin n_clr++; last_clr = cyc; hl_flag = 1'b0; end
      if (chg_req && !chg_ack) begin
        if (lat_cnt >= ack_lat) begin chg_ack = 1'b1; lat_cnt = 0; end
        else lat_cnt++;
      end else if (!chg_req && chg_ack) begin
        chg_ack = 1'b0; last_fall = cyc;
      end
      tok_in = 1'b0;
      if (tok_seen != tok_req_cnt) begin tok_in = 1'b1; tok_seen = tok_req_cnt; drv_cyc = cyc; end
      if (hl_seen != hl_req_cnt) begin hl_flag = 1'b1; hl_seen = hl_req_cnt; end
      prev_req = chg_req; prev_tok = tok_out;
      if (b_req && !b_prev_req) b_rise++;
      if (b_tok_out) b_tok++;
      b_ack = b_req;
      b_prev_req = b_req;
    end
  end

  int n_checks = 0, n_fail = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic kick(input bit tok, input bit hl);
    @(posedge clk); #1;
    if (tok) tok_req_cnt++;
    if (hl)  hl_req_cnt++;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; hold = 8'd0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);
    check(!chg_req, "R1 chg_req idle", int'(chg_req), 0);
    check(!tok_out && n_tok == 0, "R1 tok_out idle", n_tok, 0);
    check(!hl_clr && n_clr == 0, "R1 hl_clr idle", n_clr, 0);
  endtask

  task automatic t_token_basic;
    int t0, r0, c0;
    t0 = n_tok; r0 = n_rise; c0 = n_clr;
    ack_lat = 0; hold = 8'd10;
    kick(1'b1, 1'b0);
    repeat (30) @(negedge clk);
    check(last_rise == drv_cyc + 2, "R2 request timing", last_rise - drv_cyc, 2);
    check(n_tok - t0 == 1, "R3 one pass", n_tok - t0, 1);
    check(last_tok == drv_cyc + 12, "R3 hold-limited pass", last_tok - drv_cyc, 12);
    check(n_clr == c0, "R6 no clear on token", n_clr - c0, 0);
    check(n_rise - r0 == 1, "R2 one request", n_rise - r0, 1);
  endtask

  task automatic t_slow_ack;
    int t0;
    t0 = n_tok;
    ack_lat = 15; hold = 8'd2;
    kick(1'b1, 1'b0);
    repeat (60) @(negedge clk);
    check(n_tok - t0 == 1, "R3 slow ack pass count", n_tok - t0, 1);
    check(last_tok > last_fall, "R3 pass after ack fall", last_tok, last_fall + 1);
  endtask

  task automatic t_high_load;
    int t0, r0, c0;
    t0 = n_tok; r0 = n_rise; c0 = n_clr;
    ack_lat = 1;
    kick(1'b0, 1'b1);
    repeat (20) @(negedge clk);
    check(n_clr - c0 == 1, "R5 clear pulse", n_clr - c0, 1);
    check(n_rise - r0 == 1, "R5 high-load request", n_rise - r0, 1);
    check(n_tok == t0, "R6 no pass on high-load", n_tok - t0, 0);
    check(!hl_flag, "R5 latch cleared", int'(hl_flag), 0);
  endtask

  task automatic t_both;
    int t0, r0, c0;
    t0 = n_tok; r0 = n_rise; c0 = n_clr;
    ack_lat = 1; hold = 8'd3;
    kick(1'b1, 1'b1);
    repeat (40) @(negedge clk);
    check(n_rise - r0 == 2, "R7 two handshakes", n_rise - r0, 2);
    check(n_clr - c0 == 1 && n_tok - t0 == 1, "R7 both served", n_clr - c0 + n_tok - t0, 2);
    check(last_clr < last_rise, "R7 high-load first", last_clr, last_rise - 1);
  endtask

  task automatic t_dup_token;
    int t0, r0;
    t0 = n_tok; r0 = n_rise;
    ack_lat = 0; hold = 8'd20;
    kick(1'b1, 1'b0);
    repeat (8) @(negedge clk);
    kick(1'b1, 1'b0);
    repeat (50) @(negedge clk);
    check(n_tok - t0 == 1, "R9 single pass", n_tok - t0, 1);
    check(n_rise - r0 == 1, "R9 single request", n_rise - r0, 1);
  endtask

  initial begin
    t_reset;
    t_token_basic;
    t_slow_ack;
    t_high_load;
    t_both;
    t_dup_token;
    check(viol_r8 == 0, "R8 four-phase order", viol_r8, 0);
    check(viol_r4 == 0, "R4 pulse width", viol_r4, 0);
    check(b_tok == 1, "R10 boot token pass", b_tok, 1);
    check(b_rise == 1, "R10 boot request", b_rise, 1);
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  [TB] %0d tests run, %0d failed", n_checks + 1, n_fail + 1);
    $finish;
  end

endmodule